// File: doc/BRIEF.md
# System Configuration Register Block

This block is a 32-bit register file that sits on a simple memory-mapped bus with a 4 KB byte-address window. Software uses it for two scratch/control words, eight LED outputs, fixed identification words and a clock-lock status word with a writable mask. All accesses are full little-endian 32-bit words. A write is a single-cycle strobe with address and data. A read strobe returns its data on the next clock.

The block also carries an indirect configuration channel into a small table of oscillator frequency words. Software first places a value in the outgoing-data register. It then writes the channel control word, which holds a device index, a function code, a direction bit and a start bit. When start is set, the transaction finishes in that same write cycle. A write transaction copies the outgoing data into the chosen table entry. A read transaction copies the entry into the return-data register. The channel status register then reports done, and it also reports error if the function code or the device index is not valid.

Register byte offsets:

| Offset | Register |
|--------|----------|
| 0x000 | config0 |
| 0x004 | config1 |
| 0x00C | config3 |
| 0x010 | config4 |
| 0x0A0 | return data |
| 0x0A4 | outgoing data |
| 0x0A8 | channel control |
| 0x0AC | channel status |
| 0x100 | lock status |
| 0xFF8 | auxiliary ID |
| 0xFFC | ID |

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the registers read as follows. Config0, config1, return data, outgoing data and channel status read 0. Channel control reads 0x00100000. Lock status reads 0xFFFF0001. The oscillator entries 0, 1 and 2 hold 50000000, 24576000 and 25000000; these values are parameters.
- R2: Config0 (0x000), config1 (0x004) and outgoing data (0x0A4) read back the last full word written to them. The LED output always equals config1 bits [7:0].
- R3: A write to channel control (0x0A8) stores the written word with bits [19:12], [29:26] and 31 forced to 0. Bits [11:0] (device index), [25:20] (function code) and 30 (direction, 1 = write) are kept.
- R4: Every write to channel control clears channel status (0x0AC) first. If the start bit is 0, status stays 0 and neither the table nor return data changes.
- R5: A control write with start = 1, function code 1 and device index below 3 leaves status = 1. Bit 0 (done) is set and bit 1 (error) is clear. Status bits [31:2] always read 0.
- R6: A control write with start = 1 and either a function code other than 1 or a device index of 3 or more leaves status = 3 (done and error). Neither the table nor return data changes.
- R7: A good write transaction copies the current outgoing-data word into the indexed entry. A good read transaction loads the indexed entry into return data (0x0A0).
- R8: In lock status (0x100), only bits [31:24] (the mask) are writable. Bits [23:0] always read 0x00FF0001: all eight lock flags are set and the all-locked bit is set.
- R9: Config3 (0x00C) reads 0. Config4 (0x010), auxiliary ID (0xFF8) and ID (0xFFC) read their parameter values. Writes to these read-only offsets, to return data and to channel status have no effect.
- R10: Reads from any offset not listed above, including unaligned offsets, return 0. Writes to such offsets change nothing.
- R11: Read data appears on the clock after the read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per word |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte address within the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| ledOut | output | 8 | LED drive, equal to config1 bits [7:0] |

## Verification
The hardest state to reach is an error transaction that happens after earlier good transactions have already changed both the table and return data. Only in that state does "nothing changes on error" differ from "nothing has changed yet." The stimulus therefore mixes random outgoing-data writes and good transactions with bad function codes and device indices at the boundary (index 3) and beyond. It reads return data and every table entry back through good read transactions. A bench model tracks each register and entry.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [11:0] OFF_CFG0  = 12'h000;
  localparam logic [11:0] OFF_CFG1  = 12'h004;
  localparam logic [11:0] OFF_CFG3  = 12'h00C;
  localparam logic [11:0] OFF_CFG4  = 12'h010;
  localparam logic [11:0] OFF_RTN   = 12'h0A0;
  localparam logic [11:0] OFF_OUT   = 12'h0A4;
  localparam logic [11:0] OFF_CTRL  = 12'h0A8;
  localparam logic [11:0] OFF_STAT  = 12'h0AC;
  localparam logic [11:0] OFF_LOCK  = 12'h100;
  localparam logic [11:0] OFF_AUXID = 12'hFF8;
  localparam logic [11:0] OFF_ID    = 12'hFFC;

  // Control-word bits that survive a write: direction, function, device
  localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [23:0]       LOCK_FIXED = 24'hFF_0001;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_CFG0, SEL_CFG1, SEL_CFG4, SEL_RTN, SEL_OUT,
    SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_AUXID, SEL_ID
  } rdSel_t;

  typedef struct packed {
    logic        wrCfg0;
    logic        wrCfg1;
    logic        wrOut;
    logic        wrCtrl;
    logic        wrLock;
    logic        chanStart;
    logic        chanErr;
    logic        oscWr;
    logic        rtnLd;
    logic [11:0] devIdx;
    logic        rdLoad;
    rdSel_t      rdSel;
  } sysctlStrb_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [11:0]       addr,
  input  logic [WORD_W-1:0] wrData,
  output sysctlStrb_t       strb
);

  logic [5:0]  funcCode;
  logic [11:0] devField;
  logic        badReq;

  assign funcCode = wrData[25:20];
  assign devField = wrData[11:0];
  assign badReq   = (funcCode != 6'd1) || ({20'd0, devField} >= NUM_OSC);

  always_comb begin
    strb           = '0;
    strb.wrCfg0    = wrEn && (addr == OFF_CFG0);
    strb.wrCfg1    = wrEn && (addr == OFF_CFG1);
    strb.wrOut     = wrEn && (addr == OFF_OUT);
    strb.wrCtrl    = wrEn && (addr == OFF_CTRL);
    strb.wrLock    = wrEn && (addr == OFF_LOCK);
    strb.chanStart = strb.wrCtrl && wrData[31];
    strb.chanErr   = strb.chanStart && badReq;
    strb.oscWr     = strb.chanStart && !badReq && wrData[30];
    strb.rtnLd     = strb.chanStart && !badReq && !wrData[30];
    strb.devIdx    = devField;
    strb.rdLoad    = rdEn;
    unique case (addr)
      OFF_CFG0:  strb.rdSel = SEL_CFG0;
      OFF_CFG1:  strb.rdSel = SEL_CFG1;
      OFF_CFG4:  strb.rdSel = SEL_CFG4;
      OFF_RTN:   strb.rdSel = SEL_RTN;
      OFF_OUT:   strb.rdSel = SEL_OUT;
      OFF_CTRL:  strb.rdSel = SEL_CTRL;
      OFF_STAT:  strb.rdSel = SEL_STAT;
      OFF_LOCK:  strb.rdSel = SEL_LOCK;
      OFF_AUXID: strb.rdSel = SEL_AUXID;
      OFF_ID:    strb.rdSel = SEL_ID;
      default:   strb.rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int unsigned              NUM_OSC    = 3,
  parameter logic [NUM_OSC*WORD_W-1:0] OSC_RESET = {32'd25000000, 32'd24576000, 32'd50000000},
  parameter logic [WORD_W-1:0]        CFG4_VAL   = 32'h0000_0002,
  parameter logic [WORD_W-1:0]        AUX_ID_VAL = 32'h0102_0304,
  parameter logic [WORD_W-1:0]        ID_VAL     = 32'h4151_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  sysctlStrb_t       strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [7:0]        ledOut
);

  logic [WORD_W-1:0] cfg0Q, cfg1Q, rtnQ, outQ, ctrlQ;
  logic [1:0]        statQ;
  logic [7:0]        lockMaskQ;
  logic [WORD_W-1:0] oscQ [NUM_OSC];
  logic [WORD_W-1:0] oscSel;
  logic [WORD_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg0Q     <= '0;
      cfg1Q     <= '0;
      outQ      <= '0;
      rtnQ      <= '0;
      ctrlQ     <= CTRL_RESET;
      statQ     <= '0;
      lockMaskQ <= 8'hFF;
    end else begin
      if (strb.wrCfg0) cfg0Q <= wrData;
      if (strb.wrCfg1) cfg1Q <= wrData;
      if (strb.wrOut)  outQ  <= wrData;
      if (strb.wrLock) lockMaskQ <= wrData[31:24];
      if (strb.wrCtrl) begin
        ctrlQ <= wrData & CTRL_KEEP;
        statQ <= {strb.chanErr, strb.chanStart};
      end
      if (strb.rtnLd) rtnQ <= oscSel;
    end
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        oscQ[g] <= OSC_RESET[g*WORD_W +: WORD_W];
      end else if (strb.oscWr && (strb.devIdx == 12'(g))) begin
        oscQ[g] <= outQ;
      end
    end
  end

  always_comb begin
    oscSel = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (strb.devIdx == 12'(i)) oscSel = oscQ[i];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CFG0:  rdMux = cfg0Q;
      SEL_CFG1:  rdMux = cfg1Q;
      SEL_CFG4:  rdMux = CFG4_VAL;
      SEL_RTN:   rdMux = rtnQ;
      SEL_OUT:   rdMux = outQ;
      SEL_CTRL:  rdMux = ctrlQ;
      SEL_STAT:  rdMux = {30'd0, statQ};
      SEL_LOCK:  rdMux = {lockMaskQ, LOCK_FIXED};
      SEL_AUXID: rdMux = AUX_ID_VAL;
      SEL_ID:    rdMux = ID_VAL;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdMux;
  end

  assign ledOut = cfg1Q[7:0];

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned              NUM_OSC    = 3,
  parameter logic [NUM_OSC*WORD_W-1:0] OSC_RESET = {32'd25000000, 32'd24576000, 32'd50000000},
  parameter logic [WORD_W-1:0]        CFG4_VAL   = 32'h0000_0002,
  parameter logic [WORD_W-1:0]        AUX_ID_VAL = 32'h0102_0304,
  parameter logic [WORD_W-1:0]        ID_VAL     = 32'h4151_0200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [11:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [7:0]  ledOut
);

  sysctlStrb_t strb;

  sysctl_ctrl #(.NUM_OSC(NUM_OSC)) i_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb)
  );

  sysctl_dp #(
    .NUM_OSC    (NUM_OSC),
    .OSC_RESET  (OSC_RESET),
    .CFG4_VAL   (CFG4_VAL),
    .AUX_ID_VAL (AUX_ID_VAL),
    .ID_VAL     (ID_VAL)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .ledOut (ledOut)
  );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [11:0] addr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [7:0]  ledOut
);

  logic mapped;
  always_comb begin
    case (addr)
      12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
      12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  // R2: LED output follows config1 writes and only those
  a_r2_led_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 12'h004) |=> (ledOut == $past(wrData[7:0])));
  a_r2_led_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 12'h004) |=> $stable(ledOut));

  // R11: read data only moves after a read strobe
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R10: unmapped reads give zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == 32'd0));

  // R9: config3 reads zero
  a_r9_cfg3_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 12'h00C) |=> (rdData == 32'd0));

  // R8: fixed low lock bits
  a_r8_lock_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 12'h100) |=> (rdData[23:0] == 24'hFF0001));

  // R3: reserved and start bits of control read zero
  a_r3_ctrl_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 12'h0A8) |=>
      (rdData[31] == 1'b0 && rdData[29:26] == 4'd0 && rdData[19:12] == 8'd0));

  // R5 / R6: status shape, error only together with done
  a_r5_stat_shape: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 12'h0AC) |=> (rdData[31:2] == 30'd0 && (!rdData[1] || rdData[0])));

endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .ledOut (ledOut)
);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] P_CFG4 = 32'h0000_0002;
  localparam logic [31:0] P_AUX  = 32'h0102_0304;
  localparam logic [31:0] P_ID   = 32'h4151_0200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  ledOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model
  logic [31:0] mCfg0, mCfg1, mRtn, mOut, mCtrl;
  logic [1:0]  mStat;
  logic [7:0]  mLock;
  logic [31:0] mOsc [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs #(.CFG4_VAL(P_CFG4), .AUX_ID_VAL(P_AUX), .ID_VAL(P_ID)) i_sysctl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ledOut(ledOut)
  );

  function automatic void modelReset();
    mCfg0 = 0; mCfg1 = 0; mRtn = 0; mOut = 0; mCtrl = 32'h0010_0000;
    mStat = 0; mLock = 8'hFF;
    mOsc[0] = 32'd50000000; mOsc[1] = 32'd24576000; mOsc[2] = 32'd25000000;
  endfunction

  function automatic void modelWrite(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h000: mCfg0 = d;
      12'h004: mCfg1 = d;
      12'h0A4: mOut  = d;
      12'h100: mLock = d[31:24];
      12'h0A8: begin
        mCtrl = d & 32'h43F0_0FFF;
        mStat = 0;
        if (d[31]) begin
          bit bad = (d[25:20] != 6'd1) || (d[11:0] >= 12'd3);
          mStat = {bad, 1'b1};
          if (!bad) begin
            if (d[30]) mOsc[d[1:0]] = mOut;
            else       mRtn = mOsc[d[1:0]];
          end
        end
      end
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'h000: return mCfg0;
      12'h004: return mCfg1;
      12'h010: return P_CFG4;
      12'h0A0: return mRtn;
      12'h0A4: return mOut;
      12'h0A8: return mCtrl;
      12'h0AC: return {30'd0, mStat};
      12'h100: return {mLock, 24'hFF0001};
      12'hFF8: return P_AUX;
      12'hFFC: return P_ID;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(logic [11:0] a);
    case (a)
      12'h000, 12'h004, 12'h0A4: return "R2";
      12'h0A8: return "R3";
      12'h0AC: return "R5";
      12'h0A0: return "R7";
      12'h100: return "R8";
      12'h00C, 12'h010, 12'hFF8, 12'hFFC: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readCheck(logic [11:0] a, string tag);
    logic [31:0] v;
    busRead(a, v);
    check(tag, v, expRead(a));
  endtask

  // read an oscillator entry through a good read transaction
  task automatic oscCheck(int idx, string tag);
    busWrite(12'h0A8, 32'h8010_0000 | 32'(idx));
    readCheck(12'h0A0, tag);
    readCheck(12'h0AC, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] addrPool [12] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
                                   12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC, 12'h200};
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readCheck(12'h000, "R1"); readCheck(12'h004, "R1"); readCheck(12'h0A0, "R1");
    readCheck(12'h0A4, "R1"); readCheck(12'h0A8, "R1"); readCheck(12'h0AC, "R1");
    readCheck(12'h100, "R1");
    check("R1", {24'd0, ledOut}, 32'd0);
    for (int i = 0; i < 3; i++) oscCheck(i, "R1");

    // R2: scratch registers and LEDs
    busWrite(12'h000, 32'hDEAD_BEEF); readCheck(12'h000, "R2");
    busWrite(12'h004, 32'h1234_56A5); readCheck(12'h004, "R2");
    check("R2", {24'd0, ledOut}, 32'h0000_00A5);

    // R3: reserved and start bits cleared in stored control
    busWrite(12'h0A8, 32'hFFFF_FFFF); readCheck(12'h0A8, "R3");
    readCheck(12'h0AC, "R6");
    // R4: control write without start clears status
    busWrite(12'h0A8, 32'h4010_0001); readCheck(12'h0AC, "R4");
    readCheck(12'h0A0, "R4");

    // R7/R5: good write then read back
    busWrite(12'h0A4, 32'h0BAD_F00D);
    busWrite(12'h0A8, 32'hC010_0002); readCheck(12'h0AC, "R5");
    oscCheck(2, "R7");
    // R6: boundary device 3, bad function, huge device
    busWrite(12'h0A4, 32'h5555_AAAA);
    busWrite(12'h0A8, 32'hC010_0003); readCheck(12'h0AC, "R6");
    busWrite(12'h0A8, 32'h8010_0003); readCheck(12'h0AC, "R6"); readCheck(12'h0A0, "R6");
    busWrite(12'h0A8, 32'hC020_0000); readCheck(12'h0AC, "R6");
    busWrite(12'h0A8, 32'hC000_0001); readCheck(12'h0AC, "R6");
    busWrite(12'h0A8, 32'hC010_0FFF); readCheck(12'h0AC, "R6");
    for (int i = 0; i < 3; i++) oscCheck(i, "R6");

    // R8: lock mask
    busWrite(12'h100, 32'h3C00_0000); readCheck(12'h100, "R8");
    busWrite(12'h100, 32'h0000_FFFE); readCheck(12'h100, "R8");

    // R9/R10: read-only and unmapped writes ignored
    busWrite(12'h00C, 32'hFFFF_FFFF); readCheck(12'h00C, "R9");
    busWrite(12'h010, 32'hFFFF_FFFF); readCheck(12'h010, "R9");
    busWrite(12'hFF8, 32'h0);         readCheck(12'hFF8, "R9");
    busWrite(12'hFFC, 32'h0);         readCheck(12'hFFC, "R9");
    busWrite(12'h0A0, 32'h1111_1111); readCheck(12'h0A0, "R9");
    busWrite(12'h0AC, 32'h3);         readCheck(12'h0AC, "R9");
    busWrite(12'h001, 32'h7777_7777); readCheck(12'h000, "R10");
    readCheck(12'h001, "R10"); readCheck(12'h008, "R10"); readCheck(12'hFF4, "R10");

    // R11: data held when no read strobe
    busRead(12'hFFC, v);
    @(negedge clk); addr = 12'h000;
    @(negedge clk);
    check("R11", rdData, P_ID);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: busWrite(addrPool[$urandom_range(0, 11)], $urandom());
        1: busWrite(12'h0A4, $urandom());
        2, 3: begin
          logic [31:0] c = $urandom();
          c[31] = ($urandom_range(0, 3) != 0);
          if ($urandom_range(0, 2) != 0) c[25:20] = 6'd1;
          if ($urandom_range(0, 2) != 0) c[11:0]  = 12'($urandom_range(0, 4));
          busWrite(12'h0A8, c);
          readCheck(12'h0AC, c[31] ? "R6" : "R4");
        end
        default: begin
          logic [11:0] a = addrPool[$urandom_range(0, 11)];
          readCheck(a, tagFor(a));
          check("R2", {24'd0, ledOut}, {24'd0, mCfg1[7:0]});
        end
      endcase
    end
    for (int i = 0; i < 3; i++) oscCheck(i, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule